// File: doc/BRIEF.md
# Ethernet Receive Descriptor Engine

This block sits behind the receive side of an Ethernet MAC. It takes the received byte stream and places it in memory buffers described by a ring of receive descriptors. Early bytes of each frame wait in a small holding queue until the address filter gives its verdict. A frame that misses the filter is discarded without touching any descriptor. A matching frame is written into the buffer of the current descriptor, after a check that the descriptor is still owned by the hardware (its empty flag is set). When a buffer fills, that descriptor is closed and the next one is fetched.

At the end of the frame the final descriptor is written back. It carries the last flag, the length of the whole frame and the error status, and a maskable frame interrupt is raised. An external reject input drops the frame. A normal collision rewinds the ring so that the descriptors are reused. If enabled, an 8-bit value taken from a parallel port (pin or output latch, bit by bit) is appended after the frame data.

Top module: `rxbd_engine`

## Requirements
- R1: No buffer write occurs before the address filter reports a match (`ar_done` with `ar_match`) for the frame. A frame reported as a miss causes no memory write and no descriptor write-back, and leaves `bd_idx` unchanged.
- R2: A pulse on `ext_reject` while the frame is being filtered or transferred drops the rest of the frame. No descriptor is written back and `bd_idx` returns to its value at frame start.
- R3: Data goes only to a descriptor whose `bd_empty` is 1. If a needed descriptor has `bd_empty` at 0, `irq_busy` pulses and the rest of the frame is discarded. `bd_idx` stays on that descriptor.
- R4: When a buffer reaches `cfg_buf_len` bytes and more data follows, that descriptor is written back with `bd_wr_last`=0 and `bd_wr_len`=`cfg_buf_len`. `irq_buf` pulses in the same cycle if the descriptor's `bd_irq` is 1, and the transfer continues in the next descriptor.
- R5: A pulse on `rx_coll` during a frame abandons it. No descriptor is written back, no frame interrupt is raised, and `bd_idx` returns to its value at frame start, so those descriptors are reused.
- R6: The final descriptor of a frame is written back with `bd_wr_last`=1 and `bd_wr_len` equal to the whole frame length. `irq_frame` pulses with it when `cfg_frame_ie` is 1.
- R7: `bd_wr_stat` on the final descriptor has the following bits: bit 0 is a CRC error (flagged with the last byte), bit 1 marks a length below MIN_FRAME, bit 2 marks a length above MAX_FRAME, and bit 3 marks a late collision seen during the frame.
- R8: With `cfg_append_en`=1, one byte is written directly after the frame data. Each bit of that byte is `pio_latch` where `pio_dir` is 1 and `pio_pin` where it is 0. If the last data byte fills the buffer, the byte goes into the next buffer. The byte is not counted in the frame length.
- R9: After a descriptor is written back, `bd_idx` goes to 0 if that descriptor's `bd_wrap` is 1, and otherwise increments by one.
- R10: `cfg_buf_len` must be at least 64. A buffer of exactly that size is closed after its 64th byte.
- R11: Frame bytes are written in arrival order to `bd_buf_base` plus the offset within the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Received byte |
| rx_crc_err | input | 1 | CRC error, valid with the last byte |
| rx_coll | input | 1 | Normal collision, abandons the frame |
| rx_late_coll | input | 1 | Late collision, reported in status |
| ar_done | input | 1 | Address filter verdict strobe |
| ar_match | input | 1 | Address filter hit, valid with `ar_done` |
| ext_reject | input | 1 | External drop request |
| cfg_buf_len | input | LW | Bytes per buffer (at least 64) |
| cfg_append_en | input | 1 | Append the parallel-port byte |
| cfg_frame_ie | input | 1 | Frame interrupt enable |
| pio_pin | input | 8 | Parallel port pin values |
| pio_dir | input | 8 | Parallel port direction, 1 = output |
| pio_latch | input | 8 | Parallel port output latch |
| bd_idx | output | IW | Current descriptor index |
| bd_empty | input | 1 | Empty flag of the current descriptor |
| bd_irq | input | 1 | Interrupt flag of the current descriptor |
| bd_wrap | input | 1 | Wrap flag of the current descriptor |
| bd_buf_base | input | AW | Buffer address of the current descriptor |
| bd_wr_en | output | 1 | Write-back strobe for descriptor `bd_idx` (clears its empty flag) |
| bd_wr_len | output | LW | Written length |
| bd_wr_last | output | 1 | Written last flag |
| bd_wr_stat | output | 4 | Written status bits |
| mem_we | output | 1 | Buffer byte write |
| mem_addr | output | AW | Buffer byte address |
| mem_wdata | output | 8 | Buffer byte data |
| irq_buf | output | 1 | Buffer-full interrupt pulse |
| irq_frame | output | 1 | Frame-received interrupt pulse |
| irq_busy | output | 1 | No empty descriptor pulse |

## Verification
Two events can fall in the same cycle: the buffer-full close and the end of the frame. When the last data byte lands exactly on the buffer boundary, the block must decide between closing the frame in that descriptor and spilling the appended byte into a fresh one. The bench provokes this with a frame length that is a multiple of the buffer length, with append both on and off, and through random lengths. It judges the result by the descriptor count, the per-descriptor lengths and last flags, and the address of the appended byte, all computed by bench functions.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_AR, S_FETCH, S_XFER, S_APPEND, S_CLOSE, S_DROP
  } rx_state_e;
  localparam int STAT_W    = 4;
  localparam int STAT_CRC  = 0;
  localparam int STAT_SHORT = 1;
  localparam int STAT_LONG = 2;
  localparam int STAT_LATE = 3;
  localparam int MIN_BUF   = 64;
endpackage

// File: rtl/rxbd_hold_fifo.sv
module rxbd_hold_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [PW:0]  wp_q, rp_q, wp_d, rp_d;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[PW] != rp_q[PW]) && (wp_q[PW-1:0] == rp_q[PW-1:0]);
  assign dout  = mem_q[rp_q[PW-1:0]];

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (flush) begin
      wp_d = '0;
      rp_d = '0;
    end else begin
      if (push && !full) wp_d = wp_q + 1'b1;
      if (pop && !empty) rp_d = rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !flush) mem_q[wp_q[PW-1:0]] <= din;
  end

  // holding queue must never overflow while early bytes wait for the filter
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> !full);
endmodule

// File: rtl/rxbd_ring.sv
module rxbd_ring #(
  parameter int NBD = 8,
  localparam int IW = (NBD > 1) ? $clog2(NBD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          wrap,
  input  logic          rewind,
  input  logic [IW-1:0] rew_idx,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] idx_d;

  always_comb begin
    idx_d = idx;
    if (rewind)    idx_d = rew_idx;
    else if (adv)  idx_d = wrap ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_d;
  end

  assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap && !rewind) |=> (idx == '0));
  assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap && !rewind) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine
  import rxbd_pkg::*;
#(
  parameter int NBD       = 8,
  parameter int AW        = 16,
  parameter int LW        = 16,
  parameter int HOLD      = 32,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  localparam int IW = (NBD > 1) ? $clog2(NBD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic              rx_crc_err,
  input  logic              rx_coll,
  input  logic              rx_late_coll,
  input  logic              ar_done,
  input  logic              ar_match,
  input  logic              ext_reject,
  input  logic [LW-1:0]     cfg_buf_len,
  input  logic              cfg_append_en,
  input  logic              cfg_frame_ie,
  input  logic [7:0]        pio_pin,
  input  logic [7:0]        pio_dir,
  input  logic [7:0]        pio_latch,
  output logic [IW-1:0]     bd_idx,
  input  logic              bd_empty,
  input  logic              bd_irq,
  input  logic              bd_wrap,
  input  logic [AW-1:0]     bd_buf_base,
  output logic              bd_wr_en,
  output logic [LW-1:0]     bd_wr_len,
  output logic              bd_wr_last,
  output logic [STAT_W-1:0] bd_wr_stat,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              irq_buf,
  output logic              irq_frame,
  output logic              irq_busy
);
  rx_state_e     st_q, st_d;
  logic          in_act_q, in_act_d;
  logic          ar_ok_q, fin_q, crc_q, late_q;
  logic [IW-1:0] start_idx_q;
  logic [AW-1:0] base_q;
  logic [LW-1:0] buf_cnt_q, frame_len_q;

  logic       accept, start, coll_abort, rej_abort, flush, pop;
  logic       f_empty, f_full, ent_eof, buf_full, last_now, full_close;
  logic [8:0] f_dout;

  assign start      = rx_valid && rx_sof && (st_q == S_IDLE) && !in_act_q;
  assign accept     = rx_valid && (in_act_q || start);
  assign coll_abort = rx_coll && in_act_q;
  assign rej_abort  = ext_reject && !coll_abort &&
                      (st_q inside {S_WAIT_AR, S_FETCH, S_XFER, S_APPEND});
  assign flush      = coll_abort || rej_abort || (st_q == S_DROP);
  assign pop        = (st_q == S_XFER) && !f_empty && !coll_abort && !rej_abort;
  assign ent_eof    = f_dout[8];
  assign buf_full   = (buf_cnt_q + LW'(1) == cfg_buf_len);
  assign last_now   = pop && ent_eof && !(cfg_append_en && buf_full);
  assign full_close = pop && buf_full && !last_now;

  rxbd_hold_fifo #(.DEPTH(HOLD), .W(9)) u_hold (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(accept),
    .din({rx_eof, rx_data}), .pop(pop), .dout(f_dout),
    .empty(f_empty), .full(f_full)
  );

  rxbd_ring #(.NBD(NBD)) u_ring (
    .clk(clk), .rst_n(rst_n), .adv(bd_wr_en), .wrap(bd_wrap),
    .rewind(coll_abort || rej_abort), .rew_idx(start_idx_q), .idx(bd_idx)
  );

  // write-back and data path
  assign bd_wr_en   = full_close || (st_q == S_CLOSE);
  assign bd_wr_last = (st_q == S_CLOSE);
  assign bd_wr_len  = bd_wr_last ? frame_len_q : cfg_buf_len;
  always_comb begin
    bd_wr_stat             = '0;
    bd_wr_stat[STAT_CRC]   = crc_q;
    bd_wr_stat[STAT_SHORT] = frame_len_q < LW'(MIN_FRAME);
    bd_wr_stat[STAT_LONG]  = frame_len_q > LW'(MAX_FRAME);
    bd_wr_stat[STAT_LATE]  = late_q;
  end
  assign mem_we    = pop || ((st_q == S_APPEND) && !coll_abort && !rej_abort);
  assign mem_addr  = base_q + AW'(buf_cnt_q);
  assign mem_wdata = (st_q == S_APPEND) ? ((pio_dir & pio_latch) | (~pio_dir & pio_pin))
                                        : f_dout[7:0];
  assign irq_buf   = full_close && bd_irq;
  assign irq_frame = (st_q == S_CLOSE) && cfg_frame_ie;
  assign irq_busy  = (st_q == S_FETCH) && !bd_empty && !coll_abort && !rej_abort;

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:    if (start) st_d = S_WAIT_AR;
      S_WAIT_AR: if (ar_done) st_d = ar_match ? S_FETCH : S_DROP;
      S_FETCH:   st_d = bd_empty ? (fin_q ? S_APPEND : S_XFER) : S_DROP;
      S_XFER: begin
        if (last_now)        st_d = cfg_append_en ? S_APPEND : S_CLOSE;
        else if (full_close) st_d = S_FETCH;
      end
      S_APPEND:  st_d = S_CLOSE;
      S_CLOSE:   st_d = S_IDLE;
      S_DROP:    if (!in_act_q) st_d = S_IDLE;
      default:   st_d = S_IDLE;
    endcase
    if (coll_abort)     st_d = S_IDLE;
    else if (rej_abort) st_d = S_DROP;
  end

  always_comb begin
    in_act_d = in_act_q;
    if (coll_abort)                in_act_d = 1'b0;
    else if (accept && rx_eof)     in_act_d = 1'b0;
    else if (start)                in_act_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      in_act_q    <= 1'b0;
      ar_ok_q     <= 1'b0;
      fin_q       <= 1'b0;
      crc_q       <= 1'b0;
      late_q      <= 1'b0;
      start_idx_q <= '0;
      base_q      <= '0;
      buf_cnt_q   <= '0;
      frame_len_q <= '0;
    end else begin
      st_q     <= st_d;
      in_act_q <= in_act_d;
      if (start) begin
        ar_ok_q     <= 1'b0;
        fin_q       <= 1'b0;
        start_idx_q <= bd_idx;
        frame_len_q <= '0;
        late_q      <= rx_late_coll;
      end else begin
        if ((st_q == S_WAIT_AR) && ar_done && ar_match) ar_ok_q <= 1'b1;
        if (full_close && ent_eof)    fin_q <= 1'b1;
        if (pop)                      frame_len_q <= frame_len_q + LW'(1);
        if (in_act_q && rx_late_coll) late_q <= 1'b1;
      end
      if (accept && rx_eof) crc_q <= rx_crc_err;
      else if (start)       crc_q <= 1'b0;
      if ((st_q == S_FETCH) && bd_empty) begin
        base_q    <= bd_buf_base;
        buf_cnt_q <= '0;
      end else if (mem_we) begin
        buf_cnt_q <= buf_cnt_q + LW'(1);
      end
    end
  end

  assert_no_early_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ar_ok_q);
  assert_buf_len_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_buf_len >= LW'(MIN_BUF));
  assert_buf_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_buf |-> (bd_wr_en && !bd_wr_last));
  assert_frame_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_frame |-> (bd_wr_en && bd_wr_last));
  assert_busy_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_busy |=> !mem_we);
  assert_coll_no_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    coll_abort |=> !bd_wr_en);
endmodule

// File: tb/sim_rxbd_engine.sv
module sim_rxbd_engine;
  localparam int NBD = 8, AW = 16, LW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_err = 0, rx_coll = 0, rx_late_coll = 0;
  logic [7:0] rx_data = 0;
  logic ar_done = 0, ar_match = 0, ext_reject = 0;
  logic [LW-1:0] cfg_buf_len = 64;
  logic cfg_append_en = 0, cfg_frame_ie = 1;
  logic [7:0] pio_pin = 0, pio_dir = 0, pio_latch = 0;
  logic [2:0] bd_idx;
  logic bd_empty, bd_irq, bd_wrap;
  logic [AW-1:0] bd_buf_base;
  logic bd_wr_en, bd_wr_last, mem_we, irq_buf, irq_frame, irq_busy;
  logic [LW-1:0] bd_wr_len;
  logic [3:0] bd_wr_stat;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  logic m_e [NBD], m_irq [NBD], m_wrap [NBD];
  int   wb_len [NBD], wb_last [NBD], wb_stat [NBD];
  logic [7:0] mem [1024];
  logic [7:0] frm [512];
  int cnt_mem, cnt_wb, cnt_ib, cnt_if, cnt_busy;
  int n_chk = 0, n_fail = 0;

  assign bd_empty    = m_e[bd_idx];
  assign bd_irq      = m_irq[bd_idx];
  assign bd_wrap     = m_wrap[bd_idx];
  assign bd_buf_base = AW'(bd_idx) * AW'(128);

  rxbd_engine #(.NBD(NBD), .AW(AW), .LW(LW), .MAX_FRAME(256)) u0 (.*);

  always @(posedge clk) begin
    if (mem_we) begin mem[mem_addr[9:0]] <= mem_wdata; cnt_mem <= cnt_mem + 1; end
    if (bd_wr_en) begin
      m_e[bd_idx] <= 1'b0; wb_len[bd_idx] <= bd_wr_len;
      wb_last[bd_idx] <= bd_wr_last; wb_stat[bd_idx] <= bd_wr_stat;
      cnt_wb <= cnt_wb + 1;
    end
    if (irq_buf)   cnt_ib <= cnt_ib + 1;
    if (irq_frame) cnt_if <= cnt_if + 1;
    if (irq_busy)  cnt_busy <= cnt_busy + 1;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic prep();
    for (int k = 0; k < NBD; k++) begin
      m_e[k] = 1; m_irq[k] = (k % 2 == 0); m_wrap[k] = (k == NBD - 1);
      wb_len[k] = -1; wb_last[k] = -1; wb_stat[k] = -1;
    end
    cnt_mem = 0; cnt_wb = 0; cnt_ib = 0; cnt_if = 0; cnt_busy = 0;
  endtask

  task automatic fill(int len);
    for (int i = 0; i < len; i++) frm[i] = 8'($urandom_range(0, 255));
    pio_pin = 8'($urandom); pio_dir = 8'($urandom); pio_latch = 8'($urandom);
  endtask

  task automatic send(int len, int ar_at, bit match, int rej_at, int coll_at, bit crc, int late_at);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == coll_at) begin
        rx_valid = 0; ar_done = 0; ext_reject = 0; rx_coll = 1;
        @(negedge clk); rx_coll = 0;
        break;
      end
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1); rx_data = frm[i];
      rx_crc_err = (i == len - 1) && crc; ar_done = (i == ar_at); ar_match = match;
      ext_reject = (i == rej_at); rx_late_coll = (i == late_at);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_err = 0; ar_done = 0;
    ext_reject = 0; rx_late_coll = 0;
    repeat (60) @(negedge clk);
  endtask

  function automatic int exp_stat(int len, bit crc, bit late);
    return int'(crc) | ((len < 64) ? 2 : 0) | ((len > 256) ? 4 : 0) | (late ? 8 : 0);
  endfunction

  task automatic check_good(int len, int b, bit app, int start, int stat);
    int t, n, ib, bad, idx, last_idx;
    logic [7:0] appb, e;
    t = len + int'(app); n = (t + b - 1) / b; ib = 0; bad = 0;
    appb = (pio_dir & pio_latch) | (~pio_dir & pio_pin);
    chk("R6", "writebacks", cnt_wb, n);
    for (int k = 0; k < n; k++) begin
      idx = (start + k) % NBD;
      if (k < n - 1) begin
        chk("R4", "mid len", wb_len[idx], b);
        chk("R4", "mid last", wb_last[idx], 0);
        if (m_irq[idx]) ib++;
      end else begin
        chk("R6", "last len", wb_len[idx], len);
        chk("R6", "last flag", wb_last[idx], 1);
        chk("R7", "status", wb_stat[idx], stat);
      end
    end
    chk("R4", "irq_buf count", cnt_ib, ib);
    chk("R6", "irq_frame count", cnt_if, 1);
    chk("R9", "ring index", int'(bd_idx), (start + n) % NBD);
    for (int j = 0; j < len; j++) begin
      idx = (start + j / b) % NBD;
      e = frm[j];
      if (mem[idx * 128 + j % b] !== e) bad++;
    end
    chk("R11", "data mismatches", bad, 0);
    if (app) begin
      idx = (start + len / b) % NBD;
      last_idx = idx * 128 + len % b;
      chk("R8", "appended byte", int'(mem[last_idx]), int'(appb));
    end
    chk("R8", "write count", cnt_mem, t);
  endtask

  task automatic good(int len, int b, bit app, bit crc, int late_at);
    int s;
    cfg_buf_len = LW'(b); cfg_append_en = app;
    prep(); fill(len); s = int'(bd_idx);
    send(len, $urandom_range(3, 20), 1, -1, -1, crc, late_at);
    check_good(len, b, app, s, exp_stat(len, crc, late_at >= 0));
  endtask

  initial begin
    int s;
    void'($urandom(32'h1d5e_0042));
    prep();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset mem_we", mem_we, 0);
    chk("R6", "reset bd_wr_en", bd_wr_en, 0);
    chk("R6", "reset irqs", {irq_buf, irq_frame, irq_busy}, 0);
    chk("R9", "reset index", bd_idx, 0);

    // R1: filter miss
    cfg_buf_len = 128; prep(); fill(100); s = bd_idx;
    send(100, 10, 0, -1, -1, 0, -1);
    chk("R1", "miss mem writes", cnt_mem, 0);
    chk("R1", "miss writebacks", cnt_wb, 0);
    chk("R1", "miss index", bd_idx, s);

    // R2: external reject
    prep(); fill(100); s = bd_idx;
    send(100, 8, 1, 30, -1, 0, -1);
    chk("R2", "reject writebacks", cnt_wb, 0);
    chk("R2", "reject index", bd_idx, s);
    chk("R2", "reject irq_frame", cnt_if, 0);

    // R5: collision, then the same descriptors are reused
    prep(); fill(100); s = bd_idx;
    send(100, 8, 1, -1, 40, 0, -1);
    chk("R5", "coll writebacks", cnt_wb, 0);
    chk("R5", "coll index", bd_idx, s);
    chk("R5", "coll irq_frame", cnt_if, 0);
    good(100, 128, 0, 0, -1);

    // R3: next descriptor not empty
    cfg_buf_len = 64; cfg_append_en = 0; prep(); fill(200); s = bd_idx;
    m_e[(s + 1) % NBD] = 0;
    send(200, 8, 1, -1, -1, 0, -1);
    chk("R3", "busy irq", cnt_busy, 1);
    chk("R3", "busy writebacks", cnt_wb, 1);
    chk("R3", "busy mem writes", cnt_mem, 64);
    chk("R3", "busy irq_frame", cnt_if, 0);
    chk("R3", "busy index", bd_idx, (s + 1) % NBD);

    // R8/R10: last byte fills a 64-byte buffer, append spills
    good(128, 64, 1, 0, -1);
    good(128, 64, 0, 0, -1);
    // R7: short with CRC error and late collision; long frame
    good(40, 64, 0, 1, 10);
    good(300, 128, 1, 0, -1);

    for (int r = 0; r < 25; r++)
      good($urandom_range(64, 300), $urandom_range(64, 128), 1'($urandom),
           1'($urandom), ($urandom_range(0, 3) == 0) ? 20 : -1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule